// File: doc/BRIEF.md
# Spread-Spectrum Transmit Timing Strobe Generator

This block turns one transmit clock into the timing marks that a direct-sequence spread-spectrum transmitter runs on. A programmable divider marks the start of every chip. A chip counter then tracks the position within each symbol. From that position the block drives a bit strobe, a tracking strobe and an acquisition strobe. Each strobe stays high for one whole chip.

A small synchronous write port sets three values: the clocks per chip, the chips per symbol and the modulation mode (BPSK or QPSK). A burst-start pulse restarts the timing. It also makes the first symbol of the new burst the preamble symbol, which is the only symbol that can raise the acquisition strobe. Every output comes straight from a register, so the outputs change only on a rising clock edge.

Top module: `ss_tx_strobe_gen`

## Requirements
- R1: After reset, and until the first burst start, chip_pulse, bit_strobe, trk_strobe and acq_strobe are all low.
- R2: A write to address 0x41 loads the clocks per chip P from data bits 5:0. A field value v gives P = v+1, and v = 0 is clamped to P = 2. chip_pulse is high for one clock at the start of every chip. The first such clock is the one that follows the edge where burst_start was sampled high, and later ones come every P clocks.
- R3: A write to address 0x42 loads the chips per symbol C from data bits 5:0, again as v+1 with a minimum of 2. Data bit 6 selects QPSK when it is 1 and BPSK when it is 0. A write takes effect only when cfg_we and cfg_cs are both high at a rising edge. A write to any other address, or one made with cfg_cs low, changes nothing.
- R4: trk_strobe is high for exactly the last chip (index C-1) of every symbol and is low for all other chips.
- R5: In BPSK mode bit_strobe is identical to trk_strobe.
- R6: In QPSK mode bit_strobe is also high during the chip at index C/2 (integer division, chips numbered from 0). For even C this leaves one more chip before the centre chip than after it. For odd C the counts before and after are equal.
- R7: acq_strobe is high during the last chip of the first symbol after a burst start, and stays low for every later symbol of that burst.
- R8: A burst start that arrives in the middle of a burst restarts the divider, the chip count and the preamble symbol at once.
- R9: A change to the chips per symbol or to the mode during a burst takes effect from the next symbol boundary. A change to the clocks per chip takes effect from the next chip boundary.
- R10: The three strobes change value only on a clock where chip_pulse is high, and acq_strobe is never high without trk_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, sampled on the rising edge |
| cfg_cs | input | 1 | Configuration chip select, active high |
| cfg_addr | input | 7 | Configuration register address |
| cfg_data | input | 7 | Configuration write data |
| burst_start | input | 1 | Single-clock pulse that starts or restarts a burst |
| chip_pulse | output | 1 | One-clock pulse at the start of each chip |
| bit_strobe | output | 1 | Bit timing strobe, one chip long |
| trk_strobe | output | 1 | Tracking strobe, high during the last chip of each symbol |
| acq_strobe | output | 1 | High during the last chip of the burst's preamble symbol |

## Verification
The hardest case to reach from the ports is a symbol-length change written while a symbol is already under way. The old length must finish the current symbol, and the new length must govern the next one. The bench starts a burst with four chips per symbol and issues a write for six chips during the second chip. It then checks three points: the tracking strobe at the fourth chip, its absence where the old length would have put the next one, and its presence at the end of a six-chip second symbol. A restart issued partway into a symbol is also driven, so that the preamble marking can be seen to return.

// File: rtl/ss_tx_strobe_gen.sv
module ss_tx_strobe_gen #(
  parameter int AW = 7,
  parameter int DW = 7,
  parameter int CW = 6,
  parameter int QPSK_BIT = 6,
  parameter logic [AW-1:0] CPC_ADDR = 7'h41,
  parameter logic [AW-1:0] CPS_ADDR = 7'h42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_cs,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          burst_start,
  output logic          chip_pulse,
  output logic          bit_strobe,
  output logic          trk_strobe,
  output logic          acq_strobe
);
  localparam int VW = CW + 1;

  function automatic logic [VW-1:0] decode(input logic [CW-1:0] f);
    logic [VW-1:0] v;
    v = VW'(f) + VW'(1);
    return (v < VW'(2)) ? VW'(2) : v;
  endfunction

  logic [VW-1:0] cpc_cfg, cps_cfg, cpc_act, cps_act;
  logic          qpsk_cfg, qpsk_act;
  logic [CW-1:0] div_cnt, idx;
  logic          pre, active;

  wire wr_hit = cfg_we && cfg_cs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpc_cfg  <= VW'(2);
      cps_cfg  <= VW'(8);
      qpsk_cfg <= 1'b0;
    end else if (wr_hit) begin
      if (cfg_addr == CPC_ADDR) cpc_cfg <= decode(cfg_data[CW-1:0]);
      if (cfg_addr == CPS_ADDR) begin
        cps_cfg  <= decode(cfg_data[CW-1:0]);
        qpsk_cfg <= cfg_data[QPSK_BIT];
      end
    end

  wire chip_end = active && (VW'(div_cnt) == cpc_act - VW'(1));
  wire sym_end  = chip_end && (VW'(idx) == cps_act - VW'(1));
  wire new_chip = burst_start || chip_end;
  wire new_sym  = burst_start || sym_end;

  wire [VW-1:0] cpc_nx = new_chip ? cpc_cfg : cpc_act;
  wire [VW-1:0] cps_nx = new_sym ? cps_cfg : cps_act;
  wire          q_nx   = new_sym ? qpsk_cfg : qpsk_act;
  wire          pre_nx = burst_start ? 1'b1 : (sym_end ? 1'b0 : pre);
  wire [CW-1:0] idx_nx = new_sym ? '0 : (chip_end ? idx + CW'(1) : idx);
  wire [CW-1:0] div_nx = new_chip ? '0 : (active ? div_cnt + CW'(1) : div_cnt);
  wire          last_nx = VW'(idx_nx) == cps_nx - VW'(1);
  wire          mid_nx  = VW'(idx_nx) == (cps_nx >> 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpc_act    <= VW'(2);
      cps_act    <= VW'(8);
      qpsk_act   <= 1'b0;
      div_cnt    <= '0;
      idx        <= '0;
      pre        <= 1'b0;
      active     <= 1'b0;
      chip_pulse <= 1'b0;
      bit_strobe <= 1'b0;
      trk_strobe <= 1'b0;
      acq_strobe <= 1'b0;
    end else begin
      cpc_act    <= cpc_nx;
      cps_act    <= cps_nx;
      qpsk_act   <= q_nx;
      div_cnt    <= div_nx;
      idx        <= idx_nx;
      pre        <= pre_nx;
      active     <= active || burst_start;
      chip_pulse <= new_chip;
      if (new_chip) begin
        trk_strobe <= last_nx;
        bit_strobe <= last_nx || (q_nx && mid_nx);
        acq_strobe <= pre_nx && last_nx;
      end
    end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    VW'(div_cnt) < cpc_act);

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    VW'(idx) < cps_act);

  // R5
  trk_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_strobe |-> bit_strobe);

  // R6
  centre_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !trk_strobe) |-> qpsk_act);

  // R7
  acq_trk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_strobe |-> trk_strobe);

  // R10
  trk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trk_strobe) |-> chip_pulse);

  // R10
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_strobe) |-> chip_pulse);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(chip_pulse || bit_strobe || trk_strobe || acq_strobe));
endmodule

// File: tb/ss_tx_strobe_gen_tb.sv
`timescale 1ns/1ps
module ss_tx_strobe_gen_tb;
  localparam int CLK_NS = 20;

  logic clk = 0, rst_n = 0, cfg_we = 0, cfg_cs = 0, burst_start = 0;
  logic [6:0] cfg_addr = '0, cfg_data = '0;
  logic chip_pulse, bit_strobe, trk_strobe, acq_strobe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  ss_tx_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .burst_start(burst_start),
    .chip_pulse(chip_pulse), .bit_strobe(bit_strobe),
    .trk_strobe(trk_strobe), .acq_strobe(acq_strobe));

  // {clocks-per-chip field, chips-per-symbol field, qpsk}
  localparam logic [12:0] VEC [6] = '{
    {6'd1,  6'd7,  1'b0},
    {6'd1,  6'd7,  1'b1},
    {6'd2,  6'd4,  1'b1},
    {6'd0,  6'd0,  1'b1},
    {6'd63, 6'd2,  1'b1},
    {6'd3,  6'd63, 1'b1}
  };

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic cfg_write(input logic cs, input logic [6:0] a, input logic [6:0] d);
    @(negedge clk); cfg_we = 1; cfg_cs = cs; cfg_addr = a; cfg_data = d;
    @(negedge clk); cfg_we = 0; cfg_cs = 0;
  endtask

  function automatic int dec(input int f);
    return (f + 1 < 2) ? 2 : f + 1;
  endfunction

  task automatic run_burst(input int p, input int c, input bit q, input int ncyc);
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0;
    for (int t = 0; t < ncyc; t++) begin
      int chip, ix, sym;
      if (t > 0) @(negedge clk);
      chip = t / p; ix = chip % c; sym = chip / c;
      chk(chip_pulse, (t % p) == 0, "R2", "chip_pulse");
      chk(trk_strobe, ix == c - 1, "R4", "trk_strobe");
      chk(bit_strobe, (ix == c - 1) || (q && ix == c / 2), q ? "R6" : "R5", "bit_strobe");
      chk(acq_strobe, sym == 0 && ix == c - 1, "R7", "acq_strobe");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      // R1
      chk(chip_pulse | bit_strobe | trk_strobe | acq_strobe, 1'b0, "R1", "idle outputs");
    end

    // R3: table of configurations, each written then run for two symbols
    for (int v = 0; v < 6; v++) begin
      int pf, cf; bit q;
      pf = int'(VEC[v][12:7]); cf = int'(VEC[v][6:1]); q = VEC[v][0];
      cfg_write(1'b1, 7'h41, 7'(pf));
      cfg_write(1'b1, 7'h42, {q, 6'(cf)});
      run_burst(dec(pf), dec(cf), q, 2 * dec(pf) * dec(cf) + 2);
    end

    // R3: ignored writes (chip select low, foreign address)
    cfg_write(1'b1, 7'h41, 7'd1);
    cfg_write(1'b1, 7'h42, 7'd5);
    cfg_write(1'b0, 7'h42, 7'h40);
    cfg_write(1'b1, 7'h43, 7'h7F);
    cfg_write(1'b1, 7'h40, 7'h7F);
    run_burst(2, 6, 1'b0, 26);

    // R8: restart partway through the preamble symbol
    run_burst(2, 6, 1'b0, 5);
    run_burst(2, 6, 1'b0, 26);
    chk(acq_strobe, 1'b0, "R8", "acq after restart second symbol");

    // R9: chips-per-symbol change during symbol 0
    cfg_write(1'b1, 7'h42, 7'd3);
    @(negedge clk); burst_start = 1;
    @(negedge clk); burst_start = 0;
    for (int t = 0; t < 22; t++) begin
      if (t > 0) @(negedge clk);
      if (t == 2) begin cfg_we = 1; cfg_cs = 1; cfg_addr = 7'h42; cfg_data = 7'd5; end
      if (t == 3) begin cfg_we = 0; cfg_cs = 0; end
      if (t == 6)  begin chk(trk_strobe, 1'b1, "R9", "trk end of 4-chip symbol");
                         chk(acq_strobe, 1'b1, "R9", "acq end of preamble"); end
      if (t == 8)  chk(trk_strobe, 1'b0, "R9", "trk first chip symbol 1");
      if (t == 14) chk(trk_strobe, 1'b0, "R9", "trk at old symbol end");
      if (t == 18) begin chk(trk_strobe, 1'b1, "R9", "trk end of 6-chip symbol");
                         chk(acq_strobe, 1'b0, "R9", "acq in second symbol"); end
    end

    // R1: reset clears outputs mid-burst
    rst_n = 0;
    @(negedge clk);
    chk(chip_pulse | bit_strobe | trk_strobe | acq_strobe, 1'b0, "R1", "outputs in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(chip_pulse | bit_strobe | trk_strobe | acq_strobe, 1'b0, "R1", "idle after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule